// File: doc/BRIEF.md
# Dual-Clock Fall-Through FIFO Buffer

This block is a first-in, first-out buffer that joins a producer and a consumer running on separate, free-running clocks. The two clocks may be unrelated or may be the same net. By default it holds 512 words of 18 bits in its storage array, plus one more word in a registered output stage.

The producer pushes a word by raising one enable and lowering a second, active-low enable while the buffer reports room. The consumer sees a word as soon as one is present. The first word written into an empty buffer moves into the output register by itself, whatever the read-side controls are doing, and a ready flag marks the output as valid. The consumer takes a word by lowering an active-low read enable and both active-low output enables. If either output enable is high, reads are blocked and the data output is flagged as not driven; this stands in for a tri-state bus.

A half-full flag warns the producer that the array is filling. Pointers cross between the clock domains as Gray codes through two-flop synchronizers. Reset is asynchronous, and reset and the ready flags follow a fixed edge-count timing.

Top module: `dualClockFifo`

## Requirements
- R1: A word is stored on a rising write-clock edge only when `wrEnA` is 1, `wrEnBN` is 0 and `inReady` is 1; with `wrEnA` at 0 or `wrEnBN` at 1 nothing is stored.
- R2: The output word is consumed on a rising read-clock edge only when `rdEnN`, `oeAN` and `oeBN` are all 0 and `outReady` is 1; `outReady` falls only after such an edge, unless a further word replaces it at once.
- R3: A word written into an empty buffer is loaded into the output register even while `rdEnN`, `oeAN` or `oeBN` are 1.
- R4: When both clocks are the same, `outReady` rises and the word appears on `dataOut` at the third rising edge after the edge that wrote the word into an empty buffer.
- R5: While `outReady` is 0, `dataOut` keeps the last word that was consumed.
- R6: While `rstN` is 0, `inReady`, `outReady` and `halfFull` are 0 and `dataOut` is 0, independent of both clocks.
- R7: `inReady` rises on the second rising write-clock edge after `rstN` is released. It is 0 while the array holds 512 words, measured as words written minus words moved to the output, and write attempts are ignored while it is 0.
- R8: `halfFull` is 1 when the array holds 256 or more words. It is updated on the write clock, so it rises on the write edge that reaches 256, and with both clocks the same it falls three edges after the transfer that drops the count below 256.
- R9: `dataDriven` is 1 exactly when `oeAN` and `oeBN` are both 0. While either is 1, `outReady` and `dataOut` do not change because of a read.
- R10: Words leave the buffer in the order they were accepted, and none is lost or repeated. Total capacity is the array plus the output register.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| wrClk | input | 1 | Write clock |
| wrEnA | input | 1 | Write enable, active high |
| wrEnBN | input | 1 | Write enable, active low |
| wrData | input | DATA_W | Word to store |
| inReady | output | 1 | Room available; synchronous to wrClk |
| halfFull | output | 1 | Array holds HALF_LEVEL or more words |
| rdClk | input | 1 | Read clock |
| rdEnN | input | 1 | Read enable, active low |
| oeAN | input | 1 | Output enable, active low |
| oeBN | input | 1 | Output enable, active low |
| dataOut | output | DATA_W | Registered output word |
| dataDriven | output | 1 | Output would be driven (both output enables low) |
| outReady | output | 1 | `dataOut` holds a valid unread word; synchronous to rdClk |

## Verification
The bench goes after the fall-through of the first word while every read control is inactive. A design that waits for a read request would leave `outReady` low forever. It checks the exact three-edge latency of `outReady` and the two-edge rise of `inReady` after reset; an extra or missing synchronizer stage shifts these by a cycle. It fills the buffer past 513 words to show that extra writes are dropped and that the output register adds one word of capacity; an off-by-one full compare corrupts or loses data. Streaming traffic with the output enables and the active-low write enable toggling exposes reads that slip through a disabled output, writes that ignore one enable, and a half-full flag that switches at 255 or 257.

// File: rtl/fifoPkg.sv
package fifoPkg;
  // strobes handed from the control to the datapath
  typedef struct packed {
    logic wrGo;    // store wrData at the write address this edge
    logic loadGo;  // move the word at the read address into dataOut
  } fifoStrobes_t;
endpackage

// File: rtl/syncStages.sv
module syncStages #(
  parameter int WIDTH  = 10,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain <= '0;
    end else begin
      chain[0] <= dIn;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign dOut = chain[STAGES-1];
endmodule

// File: rtl/fifoCtrl.sv
module fifoCtrl
  import fifoPkg::*;
#(
  parameter int ADDR_W     = 9,
  parameter int HALF_LEVEL = 256,
  parameter int SYNC_DEPTH = 2
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              wrEnA,
  input  logic              wrEnBN,
  input  logic              rdEnN,
  input  logic              oeAN,
  input  logic              oeBN,
  output fifoStrobes_t      stb,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              inReady,
  output logic              outReady,
  output logic              halfFull
);
  localparam int PW = ADDR_W + 1;
  localparam logic [PW-1:0] DEPTH_CNT = PW'(1) << ADDR_W;
  localparam logic [PW-1:0] HALF_CNT  = PW'(HALF_LEVEL);

  function automatic logic [PW-1:0] grayToBin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // ---------------- write domain ----------------
  logic          wrArm;
  logic [PW-1:0] wrBin, wrBinNext, wrGray, rdGraySync, rdSyncBin, wrLevelNext;
  logic          wrGo;

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) wrArm <= 1'b0;
    else       wrArm <= 1'b1;
  end

  assign wrGo        = wrEnA & ~wrEnBN & inReady;
  assign wrBinNext   = wrBin + PW'(wrGo);
  assign rdSyncBin   = grayToBin(rdGraySync);
  assign wrLevelNext = wrBinNext - rdSyncBin;

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrBin    <= '0;
      wrGray   <= '0;
      inReady  <= 1'b0;
      halfFull <= 1'b0;
    end else begin
      wrBin    <= wrBinNext;
      wrGray   <= wrBinNext ^ (wrBinNext >> 1);
      inReady  <= wrArm & (wrLevelNext != DEPTH_CNT);
      halfFull <= (wrLevelNext >= HALF_CNT);
    end
  end

  syncStages #(.WIDTH(PW), .STAGES(SYNC_DEPTH)) rdToWr (
    .clk(wrClk), .rstN(rstN), .dIn(rdGray), .dOut(rdGraySync)
  );

  // ---------------- read domain ----------------
  logic          rdArm;
  logic [PW-1:0] rdBin, rdBinNext, rdGray, wrGraySync, wrSyncBin;
  logic          notEmpty, take, loadGo;

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) rdArm <= 1'b0;
    else       rdArm <= 1'b1;
  end

  assign wrSyncBin = grayToBin(wrGraySync);
  assign notEmpty  = (wrSyncBin != rdBin);
  assign take      = outReady & ~rdEnN & ~oeAN & ~oeBN;
  assign loadGo    = rdArm & notEmpty & (~outReady | take);
  assign rdBinNext = rdBin + PW'(loadGo);

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdBin    <= '0;
      rdGray   <= '0;
      outReady <= 1'b0;
    end else begin
      rdBin  <= rdBinNext;
      rdGray <= rdBinNext ^ (rdBinNext >> 1);
      if (loadGo)    outReady <= 1'b1;
      else if (take) outReady <= 1'b0;
    end
  end

  syncStages #(.WIDTH(PW), .STAGES(SYNC_DEPTH)) wrToRd (
    .clk(rdClk), .rstN(rstN), .dIn(wrGray), .dOut(wrGraySync)
  );

  assign stb.wrGo   = wrGo;
  assign stb.loadGo = loadGo;
  assign wrAddr     = wrBin[ADDR_W-1:0];
  assign rdAddr     = rdBin[ADDR_W-1:0];
endmodule

// File: rtl/fifoDatapath.sv
module fifoDatapath
  import fifoPkg::*;
#(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 9
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  fifoStrobes_t      stb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] dataOut
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge wrClk) begin
    if (stb.wrGo) store[wrAddr] <= wrData;
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)           dataOut <= '0;
    else if (stb.loadGo) dataOut <= store[rdAddr];
  end
endmodule

// File: rtl/dualClockFifo.sv
module dualClockFifo
  import fifoPkg::*;
#(
  parameter int DATA_W     = 18,
  parameter int ADDR_W     = 9,
  parameter int HALF_LEVEL = (1 << ADDR_W) / 2
) (
  input  logic              rstN,
  input  logic              wrClk,
  input  logic              wrEnA,
  input  logic              wrEnBN,
  input  logic [DATA_W-1:0] wrData,
  output logic              inReady,
  output logic              halfFull,
  input  logic              rdClk,
  input  logic              rdEnN,
  input  logic              oeAN,
  input  logic              oeBN,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataDriven,
  output logic              outReady
);
  fifoStrobes_t      stb;
  logic [ADDR_W-1:0] wrAddr, rdAddr;

  fifoCtrl #(.ADDR_W(ADDR_W), .HALF_LEVEL(HALF_LEVEL), .SYNC_DEPTH(2)) ctrl (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .wrEnA(wrEnA), .wrEnBN(wrEnBN), .rdEnN(rdEnN), .oeAN(oeAN), .oeBN(oeBN),
    .stb(stb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .inReady(inReady), .outReady(outReady), .halfFull(halfFull)
  );

  fifoDatapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dpath (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .stb(stb),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .wrData(wrData), .dataOut(dataOut)
  );

  assign dataDriven = ~oeAN & ~oeBN;
endmodule

// File: rtl/fifoChecker.sv
module fifoChecker #(
  parameter int DATA_W = 18
) (
  input logic              wrClk,
  input logic              rdClk,
  input logic              rstN,
  input logic              inReady,
  input logic              outReady,
  input logic              halfFull,
  input logic              rdEnN,
  input logic              oeAN,
  input logic              oeBN,
  input logic              wrGo,
  input logic              loadGo,
  input logic [DATA_W-1:0] dataOut
);
  assert_full_blocks_write_R7: assert property (@(posedge wrClk) disable iff (!rstN)
    !inReady |-> !wrGo);

  assert_hold_when_idle_R5: assert property (@(posedge rdClk) disable iff (!rstN)
    !loadGo |=> $stable(dataOut));

  assert_oe_blocks_read_R9: assert property (@(posedge rdClk) disable iff (!rstN)
    (outReady && (oeAN || oeBN)) |=> outReady);

  assert_drop_needs_read_R2: assert property (@(posedge rdClk) disable iff (!rstN)
    $fell(outReady) |-> $past(!rdEnN && !oeAN && !oeBN));

  always @(posedge rdClk) begin
    if (!rstN) begin
      assert_reset_state_R6: assert (!inReady && !outReady && !halfFull);
    end
  end
endmodule

bind dualClockFifo fifoChecker #(.DATA_W(DATA_W)) chk (
  .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
  .inReady(inReady), .outReady(outReady), .halfFull(halfFull),
  .rdEnN(rdEnN), .oeAN(oeAN), .oeBN(oeBN),
  .wrGo(stb.wrGo), .loadGo(stb.loadGo), .dataOut(dataOut)
);

// File: tb/tb_dualClockFifo.sv
module tb_dualClockFifo;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 18;
  localparam int AW = 9;
  localparam int DEPTH = 1 << AW;
  localparam int HALF = DEPTH / 2;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic          rstN, wrEnA, wrEnBN, rdEnN, oeAN, oeBN;
  logic [DW-1:0] wrData;
  logic          inReady, halfFull, outReady, dataDriven;
  logic [DW-1:0] dataOut;

  dualClockFifo #(.DATA_W(DW), .ADDR_W(AW), .HALF_LEVEL(HALF)) dut (
    .rstN(rstN), .wrClk(clk), .wrEnA(wrEnA), .wrEnBN(wrEnBN), .wrData(wrData),
    .inReady(inReady), .halfFull(halfFull), .rdClk(clk), .rdEnN(rdEnN),
    .oeAN(oeAN), .oeBN(oeBN), .dataOut(dataOut), .dataDriven(dataDriven),
    .outReady(outReady)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---- behavioural reference model (both clocks are the same net) ----
  int            edgeNo, wcNow, tcNow;
  int            wcH [1:3];
  int            tcH [1:3];
  logic          mIR, mOR, mHF;
  logic [DW-1:0] mDout;
  logic [DW-1:0] q [$];
  bit            mWgo, mTake, mLoad, mAvail;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      edgeNo = 0; wcNow = 0; tcNow = 0;
      for (int i = 1; i <= 3; i++) begin wcH[i] = 0; tcH[i] = 0; end
      mIR = 0; mOR = 0; mHF = 0; mDout = '0;
      q.delete();
    end else begin
      edgeNo++;
      mWgo = wrEnA && !wrEnBN && mIR;
      if (mWgo) begin q.push_back(wrData); wcNow++; end
      mAvail = (wcH[3] != tcNow);           // write count seen through two flops
      mTake  = mOR && !rdEnN && !oeAN && !oeBN;
      mLoad  = (edgeNo >= 2) && mAvail && (!mOR || mTake);
      if (mLoad) begin mDout = q.pop_front(); tcNow++; mOR = 1; end
      else if (mTake) mOR = 0;
      mIR = (edgeNo >= 2) && ((wcNow - tcH[3]) != DEPTH);
      mHF = ((wcNow - tcH[3]) >= HALF);
      wcH[3] = wcH[2]; wcH[2] = wcH[1]; wcH[1] = wcNow;
      tcH[3] = tcH[2]; tcH[2] = tcH[1]; tcH[1] = tcNow;
    end
  end

  task automatic compareAll();
    check("R7 inReady vs model", inReady, mIR);
    check("R4 outReady vs model", outReady, mOR);
    check("R8 halfFull vs model", halfFull, mHF);
    check("R10 dataOut vs model", dataOut, mDout);
    check("R9 dataDriven", dataDriven, (!oeAN && !oeBN));
  endtask

  // drive inputs right after a falling edge, compare at the next falling edge
  task automatic cyc(input bit we, input bit weBN, input logic [DW-1:0] d,
                     input bit rdn, input bit oea, input bit oeb);
    wrEnA = we; wrEnBN = weBN; wrData = d; rdEnN = rdn; oeAN = oea; oeBN = oeb;
    @(negedge clk);
    compareAll();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 1, '0, 1, 1, 1);
  endtask

  initial begin
    rstN = 0; wrEnA = 0; wrEnBN = 1; wrData = '0; rdEnN = 1; oeAN = 1; oeBN = 1;
    repeat (5) @(negedge clk);
    check("R6 reset inReady", inReady, 0);
    check("R6 reset outReady", outReady, 0);
    check("R6 reset halfFull", halfFull, 0);
    check("R6 reset dataOut", dataOut, 0);

    rstN = 1;
    @(negedge clk);
    check("R7 inReady low after first edge", inReady, 0);
    @(negedge clk);
    check("R7 inReady high after second edge", inReady, 1);

    // R3/R4: fall-through with every read control inactive
    cyc(1, 0, 18'h2A5A5, 1, 1, 1);
    cyc(0, 1, '0, 1, 1, 1);
    check("R4 outReady low one edge after write", outReady, 0);
    cyc(0, 1, '0, 1, 1, 1);
    check("R4 outReady low two edges after write", outReady, 0);
    cyc(0, 1, '0, 1, 1, 1);
    check("R3 outReady at third edge", outReady, 1);
    check("R4 dataOut at third edge", dataOut, 18'h2A5A5);

    // R9: one output enable high blocks the read
    for (int i = 0; i < 3; i++) cyc(0, 1, '0, 0, 0, 1);
    check("R9 read blocked by oeBN", outReady, 1);
    check("R9 dataDriven low", dataDriven, 0);
    cyc(0, 1, '0, 0, 1, 0);
    check("R9 read blocked by oeAN", outReady, 1);

    // R2/R5: consume, then output holds
    cyc(0, 1, '0, 0, 0, 0);
    check("R2 outReady drops after read", outReady, 0);
    for (int i = 0; i < 3; i++) cyc(0, 1, '0, 0, 0, 0);
    check("R5 dataOut held while empty", dataOut, 18'h2A5A5);

    // R1: either enable inactive stores nothing
    for (int i = 0; i < 4; i++) cyc(1, 1, 18'h11111, 1, 1, 1);
    for (int i = 0; i < 4; i++) cyc(0, 0, 18'h22222, 1, 1, 1);
    idle(5);
    check("R1 no word stored", outReady, 0);
    check("R1 dataOut unchanged", dataOut, 18'h2A5A5);

    // R7/R8: overfill with no reads
    for (int i = 0; i < 600; i++) cyc(1, 0, DW'(i * 7 + 3), 1, 1, 1);
    idle(4);
    check("R7 inReady low when full", inReady, 0);
    check("R8 halfFull high when full", halfFull, 1);
    check("R10 head word after overfill", dataOut, DW'(3));

    // drain with a read pattern
    for (int i = 0; i < 1200; i++) cyc(0, 1, '0, (i % 3 == 1), 0, 0);
    idle(4);
    check("R8 halfFull low after drain", halfFull, 0);
    check("R5 outReady low after drain", outReady, 0);

    // mixed streaming
    for (int i = 0; i < 3000; i++)
      cyc((i % 5 != 0), (i % 11 == 0), DW'(i * 13 + 5), (i % 4 == 3), 0, (i % 7 == 0));
    for (int i = 0; i < 1200; i++) cyc(0, 1, '0, 0, 0, 0);
    check("R10 empty after final drain", outReady, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL R10 watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule